// File: doc/BRIEF.md
# Console Clock Enable Generator

This block derives every timing strobe a retro video console needs from one fast system clock, so that all downstream logic runs on that single clock and no divided clock ever reaches a flip-flop clock pin. A modulo counter turns the system clock into a video (colour) clock of about 3.57 MHz. For each video period it emits a one-cycle strobe marking the rising edge and another marking the falling edge.

A second counter steps once per video period and has three states. It turns the video clock into the processor phase clock at one third of that rate and emits strobes for its rising and falling edges. These strobes always coincide with a video rising strobe, so the two clocks keep a fixed phase relation. A further strobe marks the delayed phase used by the timer and I/O devices, one video period after each processor rise. Two level signals follow the video and processor clocks. They are meant for combinational use and for observation only.

A synchronous reset and a run control are the only inputs besides the clock. With run low, the whole chain freezes and all strobes stay low.

Top module: `cke_gen`

## Requirements
- R1: While `rst` is high, all five enable outputs are low. From the first clock edge that samples `rst` high, both reference levels read low and the counters restart at zero.
- R2: With `run` high, `vid_rise_en` pulses for exactly one system cycle once every `VID_DIV` run cycles. Run cycles are numbered from 0 after reset release, and the pulse falls in the cycles whose number modulo `VID_DIV` is `VID_DIV-1`.
- R3: `vid_fall_en` pulses for one cycle in the run cycles whose number modulo `VID_DIV` is `VID_DIV/2-1`, so it never coincides with `vid_rise_en`.
- R4: `cpu_rise_en` pulses only together with `vid_rise_en`, on every third video rise: the 1st, 4th, 7th and so on after reset.
- R5: `cpu_fall_en` pulses together with the video rise that comes `CPU_HI_VIDS` video periods after each `cpu_rise_en` (default 2). It is never high in the same cycle as `cpu_rise_en` or `per_en`.
- R6: `per_en` pulses together with the video rise that comes exactly one video period (`VID_DIV` run cycles) after each `cpu_rise_en`.
- R7: `vid_ref` goes high in the cycle after `vid_rise_en` and low in the cycle after `vid_fall_en`. `cpu_ref` does the same for `cpu_rise_en` and `cpu_fall_en`.
- R8: The first `cpu_rise_en` after reset release falls in run cycle number `VID_DIV-1`, that is, on the `VID_DIV`-th cycle with `run` high.
- R9: While `run` is low, every enable is low and both counters and both reference levels hold. When `run` returns high, counting resumes from the held position with no extra or missing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance the divider chain when high |
| vid_rise_en | output | 1 | One-cycle strobe at each video clock rising edge |
| vid_fall_en | output | 1 | One-cycle strobe at each video clock falling edge |
| cpu_rise_en | output | 1 | One-cycle strobe at each processor phase rising edge |
| cpu_fall_en | output | 1 | One-cycle strobe at each processor phase falling edge |
| per_en | output | 1 | One-cycle strobe for the delayed peripheral phase |
| vid_ref | output | 1 | Level copy of the video clock, for observation only |
| cpu_ref | output | 1 | Level copy of the processor clock, for observation only |

## Verification
The assertions check local properties on every cycle. Each video strobe is one cycle wide, rise and fall never overlap, the processor-side strobes are mutually exclusive, and the counters freeze while `run` is low. They also check that the reference levels follow their strobes one cycle later. Only the bench can show the long-range facts: the exact strobe periods, the fixed one-in-three alignment of processor and peripheral strobes to video rises across many periods, the position of the first processor rise after reset, and correct resumption after irregular pause patterns. For these it compares all outputs on every clock against a model that works by arithmetic on a count of run cycles.

// File: rtl/cke_pkg.sv
package cke_pkg;
  // Next value of a counter that wraps to zero at 'modulus'.
  function automatic int unsigned step_mod(input int unsigned cur, input int unsigned modulus);
    return (cur + 1 >= modulus) ? 0 : cur + 1;
  endfunction

  // Count position at which the processor phase falls, given its high time in video periods.
  function automatic int unsigned cpu_fall_pos(input int unsigned hi_vids);
    return hi_vids % 3;
  endfunction

  localparam int unsigned CPU_RATIO = 3;
  localparam int unsigned PER_POS   = 1;
endpackage

// File: rtl/cke_vid_div.sv
module cke_vid_div #(
  parameter int unsigned VID_DIV = 28,
  localparam int unsigned VW = $clog2(VID_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic vid_rise_en,
  output logic vid_fall_en
);
  import cke_pkg::*;

  logic [VW-1:0] vcnt;
  logic          tick;

  assign tick = run && !rst;

  always_ff @(posedge clk) begin
    if (rst)      vcnt <= '0;
    else if (run) vcnt <= VW'(step_mod(32'(vcnt), VID_DIV));
  end

  assign vid_rise_en = tick && (vcnt == VW'(VID_DIV - 1));
  assign vid_fall_en = tick && (vcnt == VW'(VID_DIV / 2 - 1));

  // R2
  vid_rise_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    vid_rise_en |=> !vid_rise_en);
  // R2
  vcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    vcnt < VW'(VID_DIV));
  // R9
  vcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(vcnt));
endmodule

// File: rtl/cke_cpu_div.sv
module cke_cpu_div #(
  parameter int unsigned CPU_HI_VIDS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vid_rise_en,
  output logic cpu_rise_en,
  output logic cpu_fall_en,
  output logic per_en
);
  import cke_pkg::*;

  localparam int unsigned FALL_POS = cpu_fall_pos(CPU_HI_VIDS);

  logic [1:0] ccnt;

  always_ff @(posedge clk) begin
    if (rst)              ccnt <= '0;
    else if (vid_rise_en) ccnt <= 2'(step_mod(32'(ccnt), CPU_RATIO));
  end

  assign cpu_rise_en = vid_rise_en && (ccnt == 2'd0);
  assign cpu_fall_en = vid_rise_en && (ccnt == 2'(FALL_POS));
  assign per_en      = vid_rise_en && (ccnt == 2'(PER_POS));

  // R6
  per_follows_rise_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rise_en |=> (ccnt == 2'(PER_POS)));
  // R9
  ccnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vid_rise_en |=> $stable(ccnt));
  // R4
  ccnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ccnt != 2'd3);
endmodule

// File: rtl/cke_ref_lvl.sv
module cke_ref_lvl (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic clr_en,
  output logic lvl
);
  always_ff @(posedge clk) begin
    if (rst)         lvl <= 1'b0;
    else if (set_en) lvl <= 1'b1;
    else if (clr_en) lvl <= 1'b0;
  end

  // R7
  ref_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> lvl);
  // R7
  ref_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> !lvl);
  // R9
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(lvl));
endmodule

// File: rtl/cke_gen.sv
module cke_gen #(
  parameter int unsigned VID_DIV     = 28,
  parameter int unsigned CPU_HI_VIDS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic vid_rise_en,
  output logic vid_fall_en,
  output logic cpu_rise_en,
  output logic cpu_fall_en,
  output logic per_en,
  output logic vid_ref,
  output logic cpu_ref
);
  localparam int unsigned NREF = 2;

  logic [NREF-1:0] ref_set;
  logic [NREF-1:0] ref_clr;
  logic [NREF-1:0] ref_lvl;

  cke_vid_div #(.VID_DIV(VID_DIV)) u_vid (
    .clk(clk), .rst(rst), .run(run),
    .vid_rise_en(vid_rise_en), .vid_fall_en(vid_fall_en)
  );

  cke_cpu_div #(.CPU_HI_VIDS(CPU_HI_VIDS)) u_cpu (
    .clk(clk), .rst(rst), .vid_rise_en(vid_rise_en),
    .cpu_rise_en(cpu_rise_en), .cpu_fall_en(cpu_fall_en), .per_en(per_en)
  );

  assign ref_set = {cpu_rise_en, vid_rise_en};
  assign ref_clr = {cpu_fall_en, vid_fall_en};

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    cke_ref_lvl u_lvl (
      .clk(clk), .rst(rst), .set_en(ref_set[g]), .clr_en(ref_clr[g]), .lvl(ref_lvl[g])
    );
  end

  assign vid_ref = ref_lvl[0];
  assign cpu_ref = ref_lvl[1];

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !(vid_rise_en || vid_fall_en || cpu_rise_en || cpu_fall_en || per_en));
  // R3
  vid_edges_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(vid_rise_en && vid_fall_en));
  // R5
  cpu_strobes_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_rise_en, cpu_fall_en, per_en}));
  // R4
  cpu_on_vid_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rise_en || cpu_fall_en || per_en) |-> (vid_rise_en && !vid_fall_en));
endmodule

// File: tb/tb_cke_gen.sv
module tb_cke_gen;
  localparam int VD = 28;
  localparam int HI = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic vid_rise_en, vid_fall_en, cpu_rise_en, cpu_fall_en, per_en, vid_ref, cpu_ref;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cke_gen #(.VID_DIV(VD), .CPU_HI_VIDS(HI)) dut (
    .clk(clk), .rst(rst), .run(run),
    .vid_rise_en(vid_rise_en), .vid_fall_en(vid_fall_en),
    .cpu_rise_en(cpu_rise_en), .cpu_fall_en(cpu_fall_en), .per_en(per_en),
    .vid_ref(vid_ref), .cpu_ref(cpu_ref)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, nm, $time, act, exp);
    end
  endtask

  // Reference model: position within the run-cycle sequence since reset.
  int  runs = 0;
  bit  m_vref = 1'b0, m_cref = 1'b0;
  int  rel_cnt = 0;
  bit  first_seen = 1'b0;

  always @(negedge clk) begin
    bit evr, evf, ecr, ecf, ep;
    string t_vr, t_vf, t_cr, t_cf, t_pe, t_rf;
    int ph, p;
    evr = 0; evf = 0; ecr = 0; ecf = 0; ep = 0;
    if (!rst && run) begin
      ph  = runs % VD;
      p   = runs / VD;
      evr = (ph == VD - 1);
      evf = (ph == VD / 2 - 1);
      ecr = evr && (p % 3 == 0);
      ep  = evr && (p % 3 == 1);
      ecf = evr && (p % 3 == HI % 3);
    end
    if (rst) begin
      t_vr = "R1"; t_vf = "R1"; t_cr = "R1"; t_cf = "R1"; t_pe = "R1"; t_rf = "R7";
    end else if (!run) begin
      t_vr = "R9"; t_vf = "R9"; t_cr = "R9"; t_cf = "R9"; t_pe = "R9"; t_rf = "R9";
    end else begin
      t_vr = "R2"; t_vf = "R3"; t_cr = "R4"; t_cf = "R5"; t_pe = "R6"; t_rf = "R7";
    end
    chk(t_vr, "vid_rise_en", vid_rise_en, evr);
    chk(t_vf, "vid_fall_en", vid_fall_en, evf);
    chk(t_cr, "cpu_rise_en", cpu_rise_en, ecr);
    chk(t_cf, "cpu_fall_en", cpu_fall_en, ecf);
    chk(t_pe, "per_en",      per_en,      ep);
    chk(t_rf, "vid_ref",     vid_ref,     m_vref);
    chk(t_rf, "cpu_ref",     cpu_ref,     m_cref);

    // R8: first processor rise lands on run cycle VD-1 after release
    if (rst) begin
      rel_cnt = 0; first_seen = 1'b0;
    end else if (run) begin
      if (cpu_rise_en && !first_seen) begin
        checks++;
        first_seen = 1'b1;
        if (rel_cnt != VD - 1) begin
          fails++;
          $display("FAIL R8 first cpu_rise_en run cycle: actual=%0d expected=%0d", rel_cnt, VD - 1);
        end
      end
      rel_cnt++;
    end

    // Advance model to the next cycle
    if (rst) begin
      runs = 0; m_vref = 1'b0; m_cref = 1'b0;
    end else begin
      if (evr) m_vref = 1'b1; else if (evf) m_vref = 1'b0;
      if (ecr) m_cref = 1'b1; else if (ecf) m_cref = 1'b0;
      if (run) runs = (runs + 1) % (3 * VD);
    end
  end

  task automatic step(input logic r, input logic g);
    @(posedge clk);
    #2;
    rst = r;
    run = g;
  endtask

  initial begin
    // R1: reset held with run low, then with run high
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    // R2..R8: continuous running over many video and processor periods
    for (int i = 0; i < 900; i++) step(1'b0, 1'b1);
    // R9: irregular pauses
    for (int i = 0; i < 1500; i++) step(1'b0, (i % 11) < 7);
    for (int i = 0; i < 600; i++) step(1'b0, (i % 5) != 2);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
    // R1, R8: reset mid-run, then release with a paused start
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 400; i++) step(1'b0, (i % 3) != 0);
    for (int i = 0; i < 500; i++) step(1'b0, 1'b1);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule